// File: doc/BRIEF.md
# Sector ECC Correction Applier

This block takes the correction results of a four-symbol ECC decoder and applies them to a 512-byte sector that already sits in a local byte-addressed buffer. The decoder presents four 32-bit result words at once. Each word names a byte offset inside the sector and an 8-bit mask of bits to flip. Once the decoder signals that it has finished, the block walks the slots in order and skips any slot that holds the reserved empty value. For every other slot it reads the named byte, XORs it with the mask and writes it back. At the end it pulses a clear to the decoder so that the next decode can start.

A per-slot flag records which corrections have already been applied. The same results may therefore be presented again within one sector without flipping any bit twice. A sector-start pulse clears these flags and latches the sector number. In large-page mode the buffer holds a page of four sectors, and the sector number selects which 512-byte window an offset lands in. If the decoder reports that the sector cannot be corrected, the block marks the sector as failed and leaves the buffer untouched. An offset outside the sector is dropped and raises a sticky error flag.

Top module: `ecc_fixup`

## Requirements
- R1: After reset, `busy`, `dec_clr`, `failed` and `bad_ofs` are low, and the block neither reads nor writes the buffer.
- R2: A high `dec_done` while the block is idle starts processing. `busy` stays high from the next cycle until the cycle in which `dec_clr` is high, inclusive, and the buffer is accessed only while `busy` is high. The number of busy cycles is one per slot, plus one per applied correction, plus one closing cycle.
- R3: In a result word, the byte offset is in bits 31:16 and the XOR mask is in bits 7:0. A correction reads the addressed byte in one cycle and, in the next cycle, writes the value read XOR the mask to the same address.
- R4: A result word equal to `EMPTY_WORD` (default 32'hFFFF_0000) is skipped without any buffer access.
- R5: Slots are processed in order from 0 to 3. Each slot is applied at most once per sector. Presenting the same results again without a sector start causes no buffer writes. Two distinct slots naming the same byte both apply.
- R6: With `large_page`=1, the buffer address is 512 × sector number + offset, where the sector number is the `sec_num` value latched by `sec_start`. With `large_page`=0, the address is the offset itself.
- R7: If `dec_fail` is high together with `dec_done`, `failed` goes high, no buffer access occurs and `dec_clr` is still pulsed.
- R8: A non-empty word with an offset of 512 or more causes no buffer access and sets `bad_ofs`. `bad_ofs` stays set until reset and survives `sec_start`.
- R9: `sec_start` clears `failed` and all per-slot applied flags, after which the same results apply again.
- R10: `dec_clr` is a single-cycle pulse at the end of each run. The block is idle in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_start | input | 1 | New-sector pulse; clears flags and latches `sec_num` |
| sec_num | input | 2 | Sector number within the page |
| large_page | input | 1 | 1: four-sector page addressing; 0: offset used directly |
| dec_done | input | 1 | Decoder has finished; results are valid |
| dec_fail | input | 1 | Decoder reports that the sector cannot be corrected |
| dec_results | input | 128 | Four result words; slot n occupies bits 32n+31:32n |
| dec_clr | output | 1 | Pulse that clears the decoder status |
| busy | output | 1 | Processing in progress |
| failed | output | 1 | Current sector was marked uncorrectable |
| bad_ofs | output | 1 | Sticky flag: an out-of-range offset was seen |
| buf_addr | output | 11 | Buffer byte address |
| buf_rd_en | output | 1 | Buffer read strobe; data is returned on the next cycle |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Corrected byte |
| buf_rdata | input | 8 | Buffer read data, one cycle after `buf_rd_en` |

## Verification
The first pattern mixes an empty slot with two distinct slots that hit the same byte. This separates skipping from applying, and it shows that the flips accumulate rather than overwrite. Presenting that pattern a second time, and then again after a sector start, tells the once-per-sector guard apart from a block that never re-applies. A large-page run at sector 2 checks that the correction lands at the page-relative address and not at the bare offset. An uncorrectable run and an out-of-range offset each show that the buffer stays untouched while the matching flag rises and `dec_clr` still closes the run.

// File: rtl/ecc_fixup.sv
module ecc_fixup #(
  parameter int          SLOTS      = 4,
  parameter int          SEC_BYTES  = 512,
  parameter int          SECTORS    = 4,
  parameter logic [31:0] EMPTY_WORD = 32'hFFFF_0000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sec_start,
  input  logic [$clog2(SECTORS)-1:0]   sec_num,
  input  logic                         large_page,
  input  logic                         dec_done,
  input  logic                         dec_fail,
  input  logic [SLOTS*32-1:0]          dec_results,
  output logic                         dec_clr,
  output logic                         busy,
  output logic                         failed,
  output logic                         bad_ofs,
  output logic [$clog2(SEC_BYTES)+$clog2(SECTORS)-1:0] buf_addr,
  output logic                         buf_rd_en,
  output logic                         buf_wr_en,
  output logic [7:0]                   buf_wdata,
  input  logic [7:0]                   buf_rdata
);
  localparam int OFS_W  = $clog2(SEC_BYTES);
  localparam int SEC_W  = $clog2(SECTORS);
  localparam int ADDR_W = OFS_W + SEC_W;
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_WR, S_FIN} state_t;
  state_t state;

  logic [SLOT_W-1:0] slot;
  logic [SLOTS-1:0]  applied;
  logic [SEC_W-1:0]  sec_q;
  logic [7:0]        mask_q;
  logic [ADDR_W-1:0] addr_q;

  logic [31:0]       cur;
  logic [15:0]       ofs;
  logic              live, in_range, take, last;
  logic [ADDR_W-1:0] addr_c;

  assign cur      = dec_results[32*slot +: 32];
  assign ofs      = cur[31:16];
  assign in_range = ofs < 16'(SEC_BYTES);
  assign live     = (state == S_CHECK) && (cur != EMPTY_WORD) && !applied[slot];
  assign take     = live && in_range;
  assign last     = slot == SLOT_W'(SLOTS - 1);
  assign addr_c   = large_page ? {sec_q, ofs[OFS_W-1:0]} : {{SEC_W{1'b0}}, ofs[OFS_W-1:0]};

  assign busy      = state != S_IDLE;
  assign dec_clr   = state == S_FIN;
  assign buf_rd_en = take;
  assign buf_wr_en = state == S_WR;
  assign buf_addr  = (state == S_WR) ? addr_q : addr_c;
  assign buf_wdata = buf_rdata ^ mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      slot    <= '0;
      applied <= '0;
      sec_q   <= '0;
      mask_q  <= '0;
      addr_q  <= '0;
      failed  <= 1'b0;
      bad_ofs <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (dec_done) begin
          slot <= '0;
          if (dec_fail) begin
            failed <= 1'b1;
            state  <= S_FIN;
          end else begin
            state <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (take) begin
            addr_q        <= addr_c;
            mask_q        <= cur[7:0];
            applied[slot] <= 1'b1;
            state         <= S_WR;
          end else begin
            if (live) begin
              applied[slot] <= 1'b1;
              bad_ofs       <= 1'b1;
            end
            if (last) state <= S_FIN;
            else      slot  <= slot + 1'b1;
          end
        end
        S_WR: begin
          if (last) state <= S_FIN;
          else begin
            slot  <= slot + 1'b1;
            state <= S_CHECK;
          end
        end
        default: state <= S_IDLE;
      endcase
      if (sec_start) begin
        applied <= '0;
        failed  <= 1'b0;
        sec_q   <= sec_num;
      end
    end
  end
endmodule

module ecc_fixup_chk #(parameter int AW = 11) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          dec_clr,
  input logic          dec_done,
  input logic          dec_fail,
  input logic          sec_start,
  input logic          failed,
  input logic          buf_rd_en,
  input logic          buf_wr_en,
  input logic [AW-1:0] buf_addr
);
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_en |=> buf_wr_en); // R3
  AST_WR_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |-> ($past(buf_rd_en) && buf_addr == $past(buf_addr))); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!buf_rd_en && !buf_wr_en)); // R2
  AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_clr |=> (!dec_clr && !busy)); // R10
  AST_FAIL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_done && dec_fail && !busy && !sec_start) |=> (failed && dec_clr && !buf_rd_en && !buf_wr_en)); // R7
endmodule

bind ecc_fixup ecc_fixup_chk #(.AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .dec_clr(dec_clr),
  .dec_done(dec_done), .dec_fail(dec_fail), .sec_start(sec_start),
  .failed(failed), .buf_rd_en(buf_rd_en), .buf_wr_en(buf_wr_en),
  .buf_addr(buf_addr)
);

// File: tb/sim_ecc_fixup.sv
`timescale 1ns/1ps
module sim_ecc_fixup;
  localparam logic [31:0] EMPTY = 32'hFFFF_0000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sec_start = 1'b0;
  logic [1:0]   sec_num = '0;
  logic         large_page = 1'b0;
  logic         dec_done = 1'b0;
  logic         dec_fail = 1'b0;
  logic [127:0] dec_results = '0;
  logic         dec_clr, busy, failed, bad_ofs;
  logic [10:0]  buf_addr;
  logic         buf_rd_en, buf_wr_en;
  logic [7:0]   buf_wdata, buf_rdata;

  logic [7:0] mem [2048];
  logic [7:0] exp_mem [2048];
  int n_checks = 0, n_fail = 0;
  int wr_cnt = 0, rd_cnt = 0, busy_cnt = 0, clr_cnt = 0;

  always #4 clk = ~clk;

  ecc_fixup u0 (
    .clk(clk), .rst_n(rst_n), .sec_start(sec_start), .sec_num(sec_num),
    .large_page(large_page), .dec_done(dec_done), .dec_fail(dec_fail),
    .dec_results(dec_results), .dec_clr(dec_clr), .busy(busy),
    .failed(failed), .bad_ofs(bad_ofs), .buf_addr(buf_addr),
    .buf_rd_en(buf_rd_en), .buf_wr_en(buf_wr_en), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata)
  );

  always @(posedge clk) begin
    if (buf_rd_en) buf_rdata <= mem[buf_addr];
    if (buf_wr_en) mem[buf_addr] <= buf_wdata;
    if (rst_n) begin
      if (buf_wr_en) wr_cnt <= wr_cnt + 1;
      if (buf_rd_en) rd_cnt <= rd_cnt + 1;
      if (busy)      busy_cnt <= busy_cnt + 1;
      if (dec_clr)   clr_cnt <= clr_cnt + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  function automatic logic [31:0] word(input int ofs, input int msk);
    return {16'(ofs), 8'h00, 8'(msk)};
  endfunction

  task automatic clear_counts;
    @(negedge clk);
    wr_cnt = 0; rd_cnt = 0; busy_cnt = 0; clr_cnt = 0;
  endtask

  task automatic run_decode(input logic [31:0] w0, w1, w2, w3, input logic fail);
    clear_counts();
    dec_results = {w3, w2, w1, w0};
    dec_fail = fail;
    dec_done = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (dec_clr) break;
    end
    dec_done = 1'b0;
    dec_fail = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_sector(input int s);
    @(negedge clk);
    sec_num = 2'(s);
    sec_start = 1'b1;
    @(negedge clk);
    sec_start = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "dec_clr after reset", int'(dec_clr), 0);
    chk("R1", "failed after reset", int'(failed), 0);
    chk("R1", "bad_ofs after reset", int'(bad_ofs), 0);
    chk("R1", "reads after reset", rd_cnt, 0);
  endtask

  task automatic t_small_mix;
    exp_mem[5]   = exp_mem[5] ^ 8'h81 ^ 8'h01;
    exp_mem[300] = exp_mem[300] ^ 8'h0F;
    run_decode(word(5, 8'h81), EMPTY, word(300, 8'h0F), word(5, 8'h01), 1'b0);
    chk("R3", "byte 5 corrected", int'(mem[5]), int'(exp_mem[5]));
    chk("R3", "byte 300 corrected", int'(mem[300]), int'(exp_mem[300]));
    chk("R4", "writes with one empty slot", wr_cnt, 3);
    chk("R2", "busy cycles 4 slots + 3 fixes + 1", busy_cnt, 8);
    chk("R10", "dec_clr pulse length", clr_cnt, 1);
    chk("R10", "idle after run", int'(busy), 0);
  endtask

  task automatic t_repeat;
    run_decode(word(5, 8'h81), EMPTY, word(300, 8'h0F), word(5, 8'h01), 1'b0);
    chk("R5", "no writes on repeat", wr_cnt, 0);
    chk("R5", "byte 5 unchanged on repeat", int'(mem[5]), int'(exp_mem[5]));
    chk("R5", "dec_clr on repeat", clr_cnt, 1);
    pulse_sector(0);
    exp_mem[300] = exp_mem[300] ^ 8'h0F;
    run_decode(EMPTY, EMPTY, word(300, 8'h0F), EMPTY, 1'b0);
    chk("R9", "re-applied after sector start", int'(mem[300]), int'(exp_mem[300]));
    chk("R9", "writes after sector start", wr_cnt, 1);
  endtask

  task automatic t_large;
    large_page = 1'b1;
    pulse_sector(2);
    exp_mem[1031] = exp_mem[1031] ^ 8'h55;
    run_decode(EMPTY, word(7, 8'h55), EMPTY, EMPTY, 1'b0);
    chk("R6", "large page byte 1031", int'(mem[1031]), int'(exp_mem[1031]));
    chk("R6", "bare offset 7 untouched", int'(mem[7]), int'(exp_mem[7]));
    large_page = 1'b0;
  endtask

  task automatic t_fail;
    pulse_sector(1);
    run_decode(word(9, 8'hFF), EMPTY, EMPTY, EMPTY, 1'b1);
    chk("R7", "failed flag", int'(failed), 1);
    chk("R7", "no access on fail", rd_cnt + wr_cnt, 0);
    chk("R7", "byte 9 untouched", int'(mem[9]), int'(exp_mem[9]));
    chk("R7", "dec_clr on fail", clr_cnt, 1);
    pulse_sector(1);
    chk("R9", "failed cleared by sector start", int'(failed), 0);
  endtask

  task automatic t_bad_ofs;
    run_decode(word(600, 8'h3C), EMPTY, EMPTY, EMPTY, 1'b0);
    chk("R8", "bad_ofs set", int'(bad_ofs), 1);
    chk("R8", "no access for bad offset", rd_cnt + wr_cnt, 0);
    chk("R8", "byte 88 untouched (600 mod 512)", int'(mem[88]), int'(exp_mem[88]));
    pulse_sector(0);
    chk("R8", "bad_ofs sticky over sector start", int'(bad_ofs), 1);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) begin
      mem[i] = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    pulse_sector(0);
    t_small_mix();
    t_repeat();
    t_large();
    t_fail();
    t_bad_ofs();
    finish_up();
  end

  initial begin
    #(8 * 50000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end
endmodule